// File: doc/BRIEF.md
# Amplifier-Synchronized ADC Conversion Sequencer

This block is the digital control for an analog-to-digital converter whose input passes through a gain stage. The gain stage runs on its own synchronization clock. The sequencer runs on the ADC clock and starts conversions in two ways: a software start pulse, or an external hardware trigger when the block is armed for auto-trigger. It places the sample-and-hold strobe at a defined point relative to the amplifier clock. It counts each conversion in ADC clock cycles and ends it with a one-cycle done pulse.

If the amplifier reports an output change while the converter is still sampling, the sequencer throws away the sample and starts the sample phase again. It accepts one conversion at a time. Any request that arrives while a conversion is pending or running is dropped and is not stored for later.

The amplifier clock and the trigger input are asynchronous. Each passes through a two-flop synchronizer before edges are detected. The change strobe and all other control inputs are synchronous to the ADC clock.

Top module: `adc_sync_seq`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, `busy`, `start_bit`, `done` and `sample_strb` are all 0.
- R2: A software start on the amplified channel (channel index parameter `AMP_CH`, default 0), taken while the synchronized amplifier clock is low, keeps `busy` high for exactly `CONV_LEN` (default 13) cycles, counted from the cycle after the start pulse.
- R3: The same start, taken while the synchronized amplifier clock is high, first spends one synchronization cycle with `busy` high and no strobe, so `busy` stays high for `CONV_LEN`+1 cycles.
- R4: `sample_strb` is high for one cycle, in the first cycle of each sample phase. In that cycle `busy` is high. `done` rises exactly `CONV_LEN` cycles after the last strobe of a conversion.
- R5: If `amp_change` is high in any of the first `SAMPLE_LEN` (default 3) cycles of an amplified-channel conversion, counted from the strobe, the cycle count returns to zero. The strobe fires again in the next cycle, `done` is not raised, and the conversion becomes longer by the number of sample cycles that were already used.
- R6: `amp_change` asserted after the sample phase has no effect on the length of the conversion or on the strobe.
- R7: A start pulse that arrives while `start_bit` is high is ignored and not queued, whatever channel it names. `conv_chan` keeps the accepted channel until the conversion ends.
- R8: With `auto_en` high on the amplified channel, a start pulse only arms the block: `start_bit` goes to 1 and `busy` stays 0. Conversion begins at the first synchronized rising edge of the amplifier clock that follows a synchronized rising edge of the trigger. The strobe appears 3 cycles after `amp_clk_in` rises, and amplifier edges seen before the trigger are ignored.
- R9: Auto-trigger mode does not run freely. After `done`, further triggers and amplifier edges start nothing until the block is armed again by a new start pulse.
- R10: A conversion on any channel other than `AMP_CH` starts its sample phase in the cycle right after the start, whatever the amplifier clock level. It lasts `CONV_LEN` cycles and ignores `amp_change`.
- R11: Rising edges of `trig_in` are at least `TRIG_GAP` (default 4) cycles apart. Further trigger edges that arrive while the block waits for the amplifier edge do not start extra conversions.
- R12: `done` is a one-cycle pulse. In the cycle where `done` is high, both `busy` and `start_bit` are already 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rst | input | 1 | Synchronous active-high reset |
| amp_clk_in | input | 1 | Amplifier synchronization clock (asynchronous) |
| trig_in | input | 1 | Hardware trigger (asynchronous) |
| sw_start | input | 1 | Software start pulse |
| auto_en | input | 1 | Auto-trigger mode select |
| chan_sel | input | CH_W | Channel requested with the start pulse |
| amp_change | input | 1 | Amplifier output changed |
| start_bit | output | 1 | High from acceptance until the conversion ends |
| busy | output | 1 | Conversion running (sync or sample/convert phase) |
| done | output | 1 | One-cycle completion pulse |
| sample_strb | output | 1 | Sample-and-hold strobe |
| conv_chan | output | CH_W | Channel of the current or last conversion |

## Verification
The bench uses the default parameters. These are a 13-cycle conversion, a 3-cycle sample window, channel 0 as the amplified channel, and 3-bit channel codes. With these values both latency cases (13 and 14 cycles) can be measured directly. An abort can be placed inside the window and a late change just past it, and an ordinary channel (5) can be compared against the amplified one. The amplifier clock is driven by hand as a level. This lets every synchronizer delay be counted exactly, including the three-cycle gap from an amplifier edge to the strobe in auto-trigger mode.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ARMED,
        SQ_WAIT_AMP,
        SQ_SYNC,
        SQ_RUN
    } seq_state_e;

    typedef struct packed {
        logic valid;     // start accepted this cycle
        logic amp;       // request targets the amplified channel
        logic auto_arm;  // wait for trigger and amplifier edge
        logic lvl_high;  // amplifier clock high at request time
    } start_req_t;

    function automatic logic in_sample_window(input int unsigned cnt,
                                              input int unsigned win);
        return cnt < win;
    endfunction

endpackage

// File: rtl/adc_sync_chain.sv
module adc_sync_chain #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/adc_rise_det.sv
module adc_rise_det #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= lvl;
    end

    assign rise = lvl & ~prev;
endmodule

// File: rtl/adc_start_gate.sv
module adc_start_gate
    import adc_seq_pkg::*;
#(
    parameter int CH_W   = 3,
    parameter int AMP_CH = 0
) (
    input  logic            sw_start,
    input  logic            idle,
    input  logic            auto_en,
    input  logic [CH_W-1:0] chan_sel,
    input  logic            amp_lvl,
    output start_req_t      req
);
    localparam logic [CH_W-1:0] AMP_CODE = CH_W'(AMP_CH);

    logic is_amp;

    always_comb begin
        is_amp       = (chan_sel == AMP_CODE);
        req.valid    = sw_start & idle;
        req.amp      = is_amp;
        req.auto_arm = is_amp & auto_en;
        req.lvl_high = amp_lvl;
    end
endmodule

// File: rtl/adc_conv_fsm.sv
module adc_conv_fsm
    import adc_seq_pkg::*;
#(
    parameter int CH_W       = 3,
    parameter int CONV_LEN   = 13,
    parameter int SAMPLE_LEN = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  start_req_t      req,
    input  logic [CH_W-1:0] chan_sel,
    input  logic            trig_rise,
    input  logic            amp_rise,
    input  logic            amp_change,
    output logic            idle,
    output logic            busy,
    output logic            start_bit,
    output logic            done,
    output logic            sample_strb,
    output logic [CH_W-1:0] conv_chan
);
    localparam int CNT_W = (CONV_LEN > 1) ? $clog2(CONV_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_LEN - 1);

    seq_state_e      state;
    logic [CNT_W-1:0] cnt;
    logic            amp_q;
    logic            abort;

    assign abort = (state == SQ_RUN) && amp_q && amp_change &&
                   in_sample_window(int'(cnt), SAMPLE_LEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            cnt       <= '0;
            amp_q     <= 1'b0;
            done      <= 1'b0;
            conv_chan <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                SQ_IDLE: begin
                    if (req.valid) begin
                        conv_chan <= chan_sel;
                        amp_q     <= req.amp;
                        cnt       <= '0;
                        if (req.auto_arm)                 state <= SQ_ARMED;
                        else if (req.amp && req.lvl_high) state <= SQ_SYNC;
                        else                              state <= SQ_RUN;
                    end
                end
                SQ_ARMED: begin
                    if (trig_rise) state <= SQ_WAIT_AMP;
                end
                SQ_WAIT_AMP: begin
                    if (amp_rise) begin
                        state <= SQ_RUN;
                        cnt   <= '0;
                    end
                end
                SQ_SYNC: begin
                    state <= SQ_RUN;
                    cnt   <= '0;
                end
                SQ_RUN: begin
                    if (abort) begin
                        cnt <= '0;
                    end else if (cnt == LAST) begin
                        state <= SQ_IDLE;
                        done  <= 1'b1;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign idle        = (state == SQ_IDLE);
    assign start_bit   = !idle;
    assign busy        = (state == SQ_SYNC) || (state == SQ_RUN);
    assign sample_strb = (state == SQ_RUN) && (cnt == '0);
endmodule

// File: rtl/adc_sync_seq.sv
module adc_sync_seq
    import adc_seq_pkg::*;
#(
    parameter int CH_W        = 3,
    parameter int AMP_CH      = 0,
    parameter int CONV_LEN    = 13,
    parameter int SAMPLE_LEN  = 3,
    parameter int SYNC_STAGES = 2,
    parameter int TRIG_GAP    = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            amp_clk_in,
    input  logic            trig_in,
    input  logic            sw_start,
    input  logic            auto_en,
    input  logic [CH_W-1:0] chan_sel,
    input  logic            amp_change,
    output logic            start_bit,
    output logic            busy,
    output logic            done,
    output logic            sample_strb,
    output logic [CH_W-1:0] conv_chan
);
    localparam int N_ASYNC = 2;  // bit 0: amplifier clock, bit 1: trigger

    logic [N_ASYNC-1:0] async_lvl;
    logic [N_ASYNC-1:0] sync_lvl;
    logic [N_ASYNC-1:0] sync_rise;
    logic               idle;
    start_req_t         req;

    adc_sync_chain #(.W(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({trig_in, amp_clk_in}),
        .q   (sync_lvl)
    );

    assign async_lvl = sync_lvl;

    adc_rise_det #(.W(N_ASYNC)) u_rise (
        .clk  (clk),
        .rst  (rst),
        .lvl  (async_lvl),
        .rise (sync_rise)
    );

    adc_start_gate #(.CH_W(CH_W), .AMP_CH(AMP_CH)) u_gate (
        .sw_start (sw_start),
        .idle     (idle),
        .auto_en  (auto_en),
        .chan_sel (chan_sel),
        .amp_lvl  (sync_lvl[0]),
        .req      (req)
    );

    adc_conv_fsm #(
        .CH_W       (CH_W),
        .CONV_LEN   (CONV_LEN),
        .SAMPLE_LEN (SAMPLE_LEN)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .chan_sel    (chan_sel),
        .trig_rise   (sync_rise[1]),
        .amp_rise    (sync_rise[0]),
        .amp_change  (amp_change),
        .idle        (idle),
        .busy        (busy),
        .start_bit   (start_bit),
        .done        (done),
        .sample_strb (sample_strb),
        .conv_chan   (conv_chan)
    );
endmodule

// File: rtl/adc_sync_seq_chk.sv
module adc_sync_seq_chk #(
    parameter int CH_W     = 3,
    parameter int CONV_LEN = 13,
    parameter int TRIG_GAP = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            trig_in,
    input logic            start_bit,
    input logic            busy,
    input logic            done,
    input logic            sample_strb,
    input logic [CH_W-1:0] conv_chan
);
    int since_s;
    int gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_s <= 0;
            gap     <= 1000;
        end else begin
            if (sample_strb)  since_s <= 1;
            else if (busy)    since_s <= since_s + 1;
            else              since_s <= 0;
            if (trig_in && !$past(trig_in)) gap <= 1;
            else if (gap < 1000)           gap <= gap + 1;
        end
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (!busy && !start_bit && !done && !sample_strb));

    a_r12_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r12_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !start_bit && $past(busy)));

    a_r4_strobe_busy: assert property (@(posedge clk) disable iff (rst)
        sample_strb |-> busy);

    a_r4_strobe_to_done: assert property (@(posedge clk) disable iff (rst)
        done |-> (since_s == CONV_LEN));

    a_r2_run_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (since_s < CONV_LEN));

    a_r7_chan_hold: assert property (@(posedge clk) disable iff (rst)
        (start_bit && $past(start_bit)) |-> $stable(conv_chan));

    a_r11_trig_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(trig_in) |-> (gap >= TRIG_GAP));
endmodule

bind adc_sync_seq adc_sync_seq_chk #(
    .CH_W     (CH_W),
    .CONV_LEN (CONV_LEN),
    .TRIG_GAP (TRIG_GAP)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .trig_in     (trig_in),
    .start_bit   (start_bit),
    .busy        (busy),
    .done        (done),
    .sample_strb (sample_strb),
    .conv_chan   (conv_chan)
);

// File: tb/adc_sync_seq_tb.sv
module adc_sync_seq_tb;
    localparam int CH_W = 3;
    localparam int AMP  = 0;
    localparam int OTH  = 5;
    localparam int LEN  = 13;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            amp_clk_in = 1'b0;
    logic            trig_in = 1'b0;
    logic            sw_start = 1'b0;
    logic            auto_en = 1'b0;
    logic [CH_W-1:0] chan_sel = '0;
    logic            amp_change = 1'b0;
    logic            start_bit, busy, done, sample_strb;
    logic [CH_W-1:0] conv_chan;

    int checks = 0;
    int errors = 0;

    typedef struct {int chan; int len; int strb;} exp_t;
    exp_t sb[$];
    int   mon_busy = 0;
    int   mon_strb = 0;

    always #5 clk = ~clk;

    adc_sync_seq u_dut (
        .clk(clk), .rst(rst), .amp_clk_in(amp_clk_in), .trig_in(trig_in),
        .sw_start(sw_start), .auto_en(auto_en), .chan_sel(chan_sel),
        .amp_change(amp_change), .start_bit(start_bit), .busy(busy),
        .done(done), .sample_strb(sample_strb), .conv_chan(conv_chan)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // monitor: measures each conversion and compares against the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) mon_busy++;
            if (sample_strb) mon_strb++;
            if (done) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R9 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(mon_busy == e.len, "R2/R3/R5 busy length", mon_busy, e.len);
                    chk(mon_strb == e.strb, "R4/R5 strobe count", mon_strb, e.strb);
                    chk(int'(conv_chan) == e.chan, "R7 channel", int'(conv_chan), e.chan);
                    chk(!start_bit && !busy, "R12 done with idle flags",
                        int'({start_bit, busy}), 0);
                end
                mon_busy = 0;
                mon_strb = 0;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sw_req(input int ch, input int len, input int ns);
        @(negedge clk);
        sw_start = 1'b1;
        chan_sel = ch[CH_W-1:0];
        if (len > 0) sb.push_back('{ch, len, ns});
        @(negedge clk);
        sw_start = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (start_bit);
        tick(2);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tick(3);
        chk(!busy && !start_bit && !done && !sample_strb, "R1 reset outputs",
            int'({busy, start_bit, done, sample_strb}), 0);
        rst = 1'b0;
        tick(1);
        chk(!busy && !start_bit && !done && !sample_strb, "R1 after release",
            int'({busy, start_bit, done, sample_strb}), 0);

        // R2: amplifier clock low
        tick(4);
        sw_req(AMP, LEN, 1);
        chk(sample_strb == 1'b1, "R4 strobe first cycle (low)", int'(sample_strb), 1);
        wait_idle();

        // R3: amplifier clock high, one sync cycle
        amp_clk_in = 1'b1;
        tick(4);
        sw_req(AMP, LEN + 1, 1);
        chk(busy && !sample_strb, "R3 sync cycle", int'({busy, sample_strb}), 2);
        tick(1);
        chk(sample_strb == 1'b1, "R4 strobe after sync", int'(sample_strb), 1);
        wait_idle();

        // R5: abort in sample phase (cycle 1)
        amp_clk_in = 1'b0;
        tick(4);
        sw_req(AMP, LEN + 2, 2);
        tick(1);
        amp_change = 1'b1;
        tick(1);
        amp_change = 1'b0;
        chk(sample_strb && !done, "R5 restart strobe", int'(sample_strb), 1);
        wait_idle();

        // R6: change past the sample window
        sw_req(AMP, LEN, 1);
        tick(3);
        amp_change = 1'b1;
        tick(1);
        amp_change = 1'b0;
        chk(!sample_strb, "R6 late change ignored", int'(sample_strb), 0);
        wait_idle();

        // R7: requests while busy are dropped
        sw_req(AMP, LEN, 1);
        tick(1);
        sw_req(OTH, 0, 0);
        chk(int'(conv_chan) == AMP, "R7 other channel refused", int'(conv_chan), AMP);
        sw_req(AMP, 0, 0);
        wait_idle();
        tick(10);
        chk(!busy && !start_bit, "R7 nothing queued", int'({busy, start_bit}), 0);

        // R10: ordinary channel with amplifier high, change ignored
        amp_clk_in = 1'b1;
        tick(4);
        sw_req(OTH, LEN, 1);
        chk(sample_strb == 1'b1, "R10 no sync cycle", int'(sample_strb), 1);
        tick(1);
        amp_change = 1'b1;
        tick(1);
        amp_change = 1'b0;
        chk(!sample_strb, "R10 change ignored", int'(sample_strb), 0);
        wait_idle();

        // R8 / R11: auto-trigger
        amp_clk_in = 1'b0;
        auto_en = 1'b1;
        tick(4);
        sw_req(AMP, LEN, 1);
        chk(start_bit && !busy, "R8 armed only", int'({start_bit, busy}), 2);
        amp_clk_in = 1'b1;
        tick(4);
        amp_clk_in = 1'b0;
        tick(4);
        chk(start_bit && !busy, "R8 amp edge before trigger ignored",
            int'({start_bit, busy}), 2);
        trig_in = 1'b1;
        tick(2);
        trig_in = 1'b0;
        tick(3);
        trig_in = 1'b1;
        tick(1);
        trig_in = 1'b0;
        tick(6);
        chk(start_bit && !busy, "R11 waiting for amp edge", int'({start_bit, busy}), 2);
        amp_clk_in = 1'b1;
        tick(2);
        chk(!sample_strb, "R8 no strobe yet", int'(sample_strb), 0);
        tick(1);
        chk(sample_strb == 1'b1, "R8 strobe after amp edge", int'(sample_strb), 1);
        wait_idle();

        // R9: no free running
        amp_clk_in = 1'b0;
        tick(4);
        trig_in = 1'b1;
        tick(2);
        trig_in = 1'b0;
        tick(6);
        amp_clk_in = 1'b1;
        tick(20);
        chk(!busy && !start_bit, "R9 no rerun without start", int'({busy, start_bit}), 0);
        auto_en = 1'b0;

        tick(4);
        chk(sb.size() == 0, "R2 all conversions completed", sb.size(), 0);
        finish_run();
    end
endmodule